// File: doc/BRIEF.md
# Way-Location Predictor for a Set-Associative Second-Level Cache

This block keeps a small direct-mapped table of way locations next to a large 4-way cache, so that most accesses enable a single tag/data way instead of all four. The table is indexed and tagged with virtual address bits, which lets its lookup run in the same cycle as address translation. The physical address that comes back from translation selects the set and the tag used to confirm the prediction. A table hit drives a one-hot way enable, and the large cache behaves like a direct-mapped array for that access. A table miss drives all four enables, giving the ordinary parallel lookup in the same number of cycles. The way that the lookup resolves is then recorded for next time.

A prediction that the physical tag compare rejects is a misprediction. This can happen because only part of the virtual tag is stored. The request is stalled for one cycle and probed again with all ways enabled, and the table entry is corrected. The block contains a tag-store model of the 4-way cache, loaded through a fill port and cleared through an invalidate port. Both ports also remove any table entry that points at the affected set and way, so a stale location can never be used. Two counters record how many responses came from a confirmed prediction and how many needed a full probe.

Top module: `lcwp_way_predictor`

## Requirements
- R1: After synchronous reset every table entry and every cache line is invalid, both counters read zero, `resp_valid` is low and `req_ready` is high.
- R2: In a cycle where a request is accepted and the table misses, `way_en` is 4'b1111 in that same cycle. On the next clock edge a response appears with `full_probe`=1, `predict_hit`=0, and `resp_hit`/`resp_way` taken from the 4-way tag compare (`resp_way`=0 on a cache miss). With no request and no re-probe, `way_en` is 0.
- R3: The table is indexed by vaddr[11:6] and tagged by vaddr[19:12]. The cache set is paddr[11:6] and its tag is paddr[31:12]. A full probe that hits writes the index's entry with the partial tag, the set and the matching way.
- R4: A request whose table entry is valid and whose partial tag matches drives `way_en` with only bit `way` set (bit w enables way w). If that way holds the physical tag, the response follows one edge later with `predict_hit`=1, `resp_hit`=1 and `resp_way` set to that way.
- R5: If the predicted way does not hold the physical tag, no response follows the next edge. In the following cycle `req_ready` is low and `way_en` is 4'b1111. The response arrives two edges after the request with `full_probe`=1. The entry is rewritten with the resolved way if the probe hit, or made invalid if it missed.
- R6: Every response carries exactly one of `predict_hit` and `full_probe`. Both are low when `resp_valid` is low.
- R7: A fill writes the tag into a cache line. An invalidate clears a cache line. Either of them invalidates every table entry whose stored set and way equal the ones addressed, so a later request to that index misses the table.
- R8: `hit_count` increments on each response with `predict_hit` and `miss_count` on each response with `full_probe`, on the same edge that raises the response.
- R9: A full probe that misses in every way (outside a re-probe) leaves the table unchanged, so the same request misses the table again.
- R10: A full-probe hit at an occupied index replaces the previous occupant, which then misses the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_vaddr | input | 32 | Virtual address, indexes and tags the table |
| req_paddr | input | 32 | Translated address, selects set and tag |
| req_ready | output | 1 | Low during a re-probe cycle; a request is ignored then |
| way_en | output | 4 | Way enables to the large cache, bit w for way w |
| fill_valid | input | 1 | Write a line into the cache tag store |
| fill_set | input | 6 | Set being filled |
| fill_way | input | 2 | Way being filled |
| fill_tag | input | 20 | Tag written |
| inv_valid | input | 1 | Invalidate a cache line |
| inv_set | input | 6 | Set being invalidated |
| inv_way | input | 2 | Way being invalidated |
| resp_valid | output | 1 | Response for the request |
| resp_hit | output | 1 | Large cache hit |
| resp_way | output | 2 | Way that hit |
| predict_hit | output | 1 | Served from a confirmed prediction |
| full_probe | output | 1 | Served by an all-way probe |
| hit_count | output | 16 | Confirmed-prediction responses |
| miss_count | output | 16 | Full-probe responses |

## Verification
`way_en` and `req_ready` depend only on the current inputs and state, so they are compared about 1 ns after the inputs change, within the cycle where the request is presented. A response and its counters are due one edge after an accepted request. After a misprediction the response is due two edges later, and the cycle in between shows the stall with all ways enabled. The reference model advances once per clock. After each rising edge it compares the registered outputs at the following falling edge, so every check falls on the cycle in which its result is due.

// File: rtl/lcwp_pkg.sv
package lcwp_pkg;
    parameter int VA_W       = 32;
    parameter int PA_W       = 32;
    parameter int LINE_OFF_W = 6;
    parameter int PRED_DEPTH = 64;
    parameter int PRED_TAG_W = 8;
    parameter int NUM_WAYS   = 4;
    parameter int NUM_SETS   = 64;
    parameter int CNT_W      = 16;
    parameter int NUM_CLR    = 2;

    localparam int PIDX_W = $clog2(PRED_DEPTH);
    localparam int WAY_W  = $clog2(NUM_WAYS);
    localparam int SET_W  = $clog2(NUM_SETS);
    localparam int CTAG_W = PA_W - LINE_OFF_W - SET_W;

    typedef logic [VA_W-1:0]       va_t;
    typedef logic [PA_W-1:0]       pa_t;
    typedef logic [PIDX_W-1:0]     pidx_t;
    typedef logic [PRED_TAG_W-1:0] ptag_t;
    typedef logic [WAY_W-1:0]      way_t;
    typedef logic [SET_W-1:0]      set_t;
    typedef logic [CTAG_W-1:0]     ctag_t;
    typedef logic [NUM_WAYS-1:0]   wayvec_t;

    typedef struct packed {
        logic  valid;
        ptag_t vtag;
        set_t  set;
        way_t  way;
    } pred_entry_t;

    typedef struct packed {
        logic  valid;
        ctag_t tag;
    } line_t;

    typedef struct packed {
        logic valid;
        logic hit;
        way_t way;
        logic pred;
        logic full;
    } resp_t;

    typedef enum logic [2:0] {
        OUT_IDLE,
        OUT_FULL,
        OUT_PRED_OK,
        OUT_PRED_BAD,
        OUT_REPROBE
    } outcome_t;

    function automatic pidx_t f_pidx(va_t va);
        return va[LINE_OFF_W +: PIDX_W];
    endfunction

    function automatic ptag_t f_ptag(va_t va);
        return va[LINE_OFF_W + PIDX_W +: PRED_TAG_W];
    endfunction

    function automatic set_t f_set(pa_t pa);
        return pa[LINE_OFF_W +: SET_W];
    endfunction

    function automatic ctag_t f_ctag(pa_t pa);
        return pa[LINE_OFF_W + SET_W +: CTAG_W];
    endfunction

    function automatic wayvec_t f_onehot(way_t w);
        return wayvec_t'(1) << w;
    endfunction
endpackage

// File: rtl/lcwp_pred_table.sv
module lcwp_pred_table import lcwp_pkg::*; (
    input  logic                  clk,
    input  logic                  rst,
    input  va_t                   lk_va,
    output logic                  lk_hit,
    output way_t                  lk_way,
    input  logic                  wr_en,
    input  logic                  wr_keep,
    input  va_t                   wr_va,
    input  set_t                  wr_set,
    input  way_t                  wr_way,
    input  logic [NUM_CLR-1:0]    clr_en,
    input  set_t [NUM_CLR-1:0]    clr_set,
    input  way_t [NUM_CLR-1:0]    clr_way
);
    pred_entry_t [PRED_DEPTH-1:0] ent_all;
    pred_entry_t                  rd;

    assign rd     = ent_all[f_pidx(lk_va)];
    assign lk_hit = rd.valid && (rd.vtag == f_ptag(lk_va));
    assign lk_way = rd.way;

    for (genvar i = 0; i < PRED_DEPTH; i++) begin : g_ent
        pred_entry_t        ent_q;
        pred_entry_t        cand;
        logic [NUM_CLR-1:0] kill;

        // a write lands first; a clear of the same set/way then removes it
        always_comb begin
            cand = ent_q;
            if (wr_en && (f_pidx(wr_va) == pidx_t'(i))) begin
                cand.valid = wr_keep;
                cand.vtag  = f_ptag(wr_va);
                cand.set   = wr_set;
                cand.way   = wr_way;
            end
            for (int k = 0; k < NUM_CLR; k++) begin
                kill[k] = clr_en[k] && (cand.set == clr_set[k]) && (cand.way == clr_way[k]);
            end
            if (|kill) cand.valid = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst) ent_q <= '0;
            else     ent_q <= cand;
        end

        assign ent_all[i] = ent_q;

        for (genvar k = 0; k < NUM_CLR; k++) begin : g_clr
            AST_STALE_ENTRY_DROPPED: assert property (@(posedge clk) disable iff (rst)
                (clr_en[k] && ent_q.valid && ent_q.set == clr_set[k] && ent_q.way == clr_way[k])
                |=> !ent_q.valid); // R7
        end
    end
endmodule

// File: rtl/lcwp_tag_store.sv
module lcwp_tag_store import lcwp_pkg::*; (
    input  logic    clk,
    input  logic    rst,
    input  logic    fill_en,
    input  set_t    fill_set,
    input  way_t    fill_way,
    input  ctag_t   fill_tag,
    input  logic    inv_en,
    input  set_t    inv_set,
    input  way_t    inv_way,
    input  set_t    pr_set,
    input  ctag_t   pr_tag,
    input  wayvec_t pr_en,
    output logic    pr_hit,
    output way_t    pr_way
);
    localparam int LINES = NUM_SETS * NUM_WAYS;

    line_t [LINES-1:0] line_all;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
            logic  fill_me;
            logic  inv_me;
            line_t line_q;

            assign fill_me = fill_en && (fill_set == set_t'(s)) && (fill_way == way_t'(w));
            assign inv_me  = inv_en  && (inv_set  == set_t'(s)) && (inv_way  == way_t'(w));

            always_ff @(posedge clk) begin
                if (rst)          line_q <= '0;
                else if (inv_me)  line_q.valid <= 1'b0;
                else if (fill_me) line_q <= '{valid: 1'b1, tag: fill_tag};
            end

            assign line_all[s*NUM_WAYS + w] = line_q;

            AST_LINE_CLEARED: assert property (@(posedge clk) disable iff (rst)
                inv_me |=> !line_q.valid); // R7
            AST_LINE_FILLED: assert property (@(posedge clk) disable iff (rst)
                (fill_me && !inv_me) |=> (line_q.valid && line_q.tag == $past(fill_tag))); // R7
        end
    end

    // lowest enabled way with a matching tag wins
    always_comb begin
        pr_hit = 1'b0;
        pr_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (pr_en[w] && line_all[int'(pr_set)*NUM_WAYS + w].valid
                         && line_all[int'(pr_set)*NUM_WAYS + w].tag == pr_tag) begin
                pr_hit = 1'b1;
                pr_way = way_t'(w);
            end
        end
    end
endmodule

// File: rtl/lcwp_way_predictor.sv
module lcwp_way_predictor import lcwp_pkg::*; (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic [PA_W-1:0]       req_paddr,
    output logic                  req_ready,
    output logic [NUM_WAYS-1:0]   way_en,
    input  logic                  fill_valid,
    input  logic [SET_W-1:0]      fill_set,
    input  logic [WAY_W-1:0]      fill_way,
    input  logic [CTAG_W-1:0]     fill_tag,
    input  logic                  inv_valid,
    input  logic [SET_W-1:0]      inv_set,
    input  logic [WAY_W-1:0]      inv_way,
    output logic                  resp_valid,
    output logic                  resp_hit,
    output logic [WAY_W-1:0]      resp_way,
    output logic                  predict_hit,
    output logic                  full_probe,
    output logic [CNT_W-1:0]      hit_count,
    output logic [CNT_W-1:0]      miss_count
);
    logic     retry_q;
    va_t      retry_va_q;
    pa_t      retry_pa_q;
    va_t      cur_va;
    pa_t      cur_pa;
    logic     lk_hit;
    way_t     lk_way;
    logic     pr_hit;
    way_t     pr_way;
    outcome_t outcome;
    resp_t    resp_d;
    resp_t    resp_q;
    logic     wr_en;
    logic [CNT_W-1:0] hit_q;
    logic [CNT_W-1:0] miss_q;

    assign req_ready = !retry_q;
    assign cur_va    = retry_q ? retry_va_q : req_vaddr;
    assign cur_pa    = retry_q ? retry_pa_q : req_paddr;

    lcwp_pred_table i_table (
        .clk     (clk),
        .rst     (rst),
        .lk_va   (req_vaddr),
        .lk_hit  (lk_hit),
        .lk_way  (lk_way),
        .wr_en   (wr_en),
        .wr_keep (pr_hit),
        .wr_va   (cur_va),
        .wr_set  (f_set(cur_pa)),
        .wr_way  (pr_way),
        .clr_en  ({inv_valid, fill_valid}),
        .clr_set ({inv_set, fill_set}),
        .clr_way ({inv_way, fill_way})
    );

    lcwp_tag_store i_tags (
        .clk      (clk),
        .rst      (rst),
        .fill_en  (fill_valid),
        .fill_set (fill_set),
        .fill_way (fill_way),
        .fill_tag (fill_tag),
        .inv_en   (inv_valid),
        .inv_set  (inv_set),
        .inv_way  (inv_way),
        .pr_set   (f_set(cur_pa)),
        .pr_tag   (f_ctag(cur_pa)),
        .pr_en    (way_en),
        .pr_hit   (pr_hit),
        .pr_way   (pr_way)
    );

    always_comb begin
        if (retry_q || (req_valid && !lk_hit)) way_en = '1;
        else if (req_valid)                    way_en = f_onehot(lk_way);
        else                                   way_en = '0;
    end

    always_comb begin
        if (retry_q)         outcome = OUT_REPROBE;
        else if (!req_valid) outcome = OUT_IDLE;
        else if (!lk_hit)    outcome = OUT_FULL;
        else if (pr_hit)     outcome = OUT_PRED_OK;
        else                 outcome = OUT_PRED_BAD;
    end

    always_comb begin
        resp_d = '0;
        unique case (outcome)
            OUT_PRED_OK: resp_d = '{valid: 1'b1, hit: 1'b1, way: pr_way, pred: 1'b1, full: 1'b0};
            OUT_FULL,
            OUT_REPROBE: resp_d = '{valid: 1'b1, hit: pr_hit, way: pr_way, pred: 1'b0, full: 1'b1};
            default:     resp_d = '0;
        endcase
    end

    // a re-probe always rewrites its entry: resolved way on hit, invalid on miss
    assign wr_en = (outcome == OUT_REPROBE) || (outcome == OUT_FULL && pr_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            retry_q    <= 1'b0;
            retry_va_q <= '0;
            retry_pa_q <= '0;
            resp_q     <= '0;
            hit_q      <= '0;
            miss_q     <= '0;
        end else begin
            retry_q <= (outcome == OUT_PRED_BAD);
            if (outcome == OUT_PRED_BAD) begin
                retry_va_q <= req_vaddr;
                retry_pa_q <= req_paddr;
            end
            resp_q <= resp_d;
            if (resp_d.pred) hit_q  <= hit_q + 1'b1;
            if (resp_d.full) miss_q <= miss_q + 1'b1;
        end
    end

    assign resp_valid  = resp_q.valid;
    assign resp_hit    = resp_q.hit;
    assign resp_way    = resp_q.way;
    assign predict_hit = resp_q.pred;
    assign full_probe  = resp_q.full;
    assign hit_count   = hit_q;
    assign miss_count  = miss_q;

    AST_ONE_FLAG_PER_RESP: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (predict_hit != full_probe)); // R6
    AST_FLAGS_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !resp_valid |-> (!predict_hit && !full_probe)); // R6
    AST_PREDICTED_WAY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && lk_hit) |-> ($countones(way_en) == 1)); // R4
    AST_PREDICT_CONFIRMED: assert property (@(posedge clk) disable iff (rst)
        predict_hit |-> resp_hit); // R4
    AST_REPROBE_STALL: assert property (@(posedge clk) disable iff (rst)
        (outcome == OUT_PRED_BAD) |=> (!req_ready && way_en == '1)); // R5
    AST_REPROBE_ANSWER: assert property (@(posedge clk) disable iff (rst)
        (outcome == OUT_PRED_BAD) |=> !resp_valid ##1 (resp_valid && full_probe)); // R5
    AST_HIT_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        predict_hit |-> (hit_count == $past(hit_count) + 1'b1)); // R8
    AST_MISS_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        full_probe |-> (miss_count == $past(miss_count) + 1'b1)); // R8
endmodule

// File: tb/test_lcwp_way_predictor.sv
`timescale 1ns/1ps
module test_lcwp_way_predictor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rq = 1'b0;
    logic [31:0] va = '0;
    logic [31:0] pa = '0;
    logic        fv = 1'b0;
    logic [5:0]  fset = '0;
    logic [1:0]  fway = '0;
    logic [19:0] ftag = '0;
    logic        iv = 1'b0;
    logic [5:0]  iset = '0;
    logic [1:0]  iway = '0;

    logic        req_ready;
    logic [3:0]  way_en;
    logic        resp_valid, resp_hit, predict_hit, full_probe;
    logic [1:0]  resp_way;
    logic [15:0] hit_count, miss_count;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string scen    = "R1";

    // reference state
    bit          m_pv [64];
    logic [7:0]  m_pt [64];
    logic [5:0]  m_ps [64];
    logic [1:0]  m_pw [64];
    bit          m_cv [64][4];
    logic [19:0] m_ct [64][4];
    bit          m_retry;
    logic [31:0] m_rva, m_rpa;
    int          m_hc, m_mc;

    always #4 clk = ~clk;

    lcwp_way_predictor i_lcwp_way_predictor (
        .clk(clk), .rst(rst),
        .req_valid(rq), .req_vaddr(va), .req_paddr(pa),
        .req_ready(req_ready), .way_en(way_en),
        .fill_valid(fv), .fill_set(fset), .fill_way(fway), .fill_tag(ftag),
        .inv_valid(iv), .inv_set(iset), .inv_way(iway),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
        .predict_hit(predict_hit), .full_probe(full_probe),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s: actual %0h expected %0h", tag, scen, what, act, exp);
        end
    endtask

    function automatic bit probe(logic [31:0] p, logic [3:0] en, output int way);
        int s = int'(p[11:6]);
        way = 0;
        for (int w = 0; w < 4; w++) begin
            if (en[w] && m_cv[s][w] && m_ct[s][w] == p[31:12]) begin
                way = w;
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    task automatic clear_ptrs(int s, int w);
        for (int i = 0; i < 64; i++)
            if (m_pv[i] && m_ps[i] == 6'(s) && m_pw[i] == 2'(w)) m_pv[i] = 1'b0;
    endtask

    // one clock: check combinational outputs, step model, check registered outputs
    task automatic tick();
        logic [31:0] cva, cpa;
        logic [3:0]  x_en;
        bit ph, hit, nretry;
        bit n_rv, n_hit, n_ph, n_fp;
        int way, n_way, idx;
        string ctag, rtag;
        ph = 0; n_rv = 0; n_hit = 0; n_ph = 0; n_fp = 0; n_way = 0; nretry = 0;
        cva = va; cpa = pa; hit = 0; way = 0; idx = 0;
        #1;
        if (m_retry) begin
            cva = m_rva; cpa = m_rpa; x_en = 4'hF; ctag = "R5";
        end else if (rq) begin
            idx  = int'(va[11:6]);
            ph   = m_pv[idx] && m_pt[idx] == va[19:12];
            x_en = ph ? (4'b0001 << m_pw[idx]) : 4'hF;
            ctag = ph ? "R4" : "R2";
        end else begin
            x_en = 4'h0; ctag = "R2";
        end
        chk(ctag, "way_en", 32'(way_en), 32'(x_en));
        chk(m_retry ? "R5" : "R1", "req_ready", 32'(req_ready), 32'(!m_retry));
        rtag = "R2";
        if (m_retry || rq) begin
            hit = probe(cpa, x_en, way);
            idx = int'(cva[11:6]);
            if (!m_retry && ph && hit) begin
                n_rv = 1; n_hit = 1; n_way = way; n_ph = 1; m_hc++; rtag = "R4";
            end else if (!m_retry && ph) begin
                nretry = 1; m_rva = va; m_rpa = pa;
            end else begin
                n_rv = 1; n_fp = 1; n_hit = hit; n_way = hit ? way : 0; m_mc++;
                rtag = m_retry ? "R5" : "R2";
                if (hit) begin
                    m_pv[idx] = 1; m_pt[idx] = cva[19:12];
                    m_ps[idx] = cpa[11:6]; m_pw[idx] = 2'(way);
                end else if (m_retry) begin
                    m_pv[idx] = 0;
                end
            end
        end
        m_retry = nretry;
        if (fv) begin
            m_cv[fset][fway] = 1; m_ct[fset][fway] = ftag;
        end
        if (iv) m_cv[iset][iway] = 0;
        if (fv) clear_ptrs(int'(fset), int'(fway));
        if (iv) clear_ptrs(int'(iset), int'(iway));
        @(posedge clk);
        @(negedge clk);
        chk(rtag, "resp_valid", 32'(resp_valid), 32'(n_rv));
        chk(rtag, "resp_hit", 32'(resp_hit), 32'(n_hit));
        chk(rtag, "resp_way", 32'(resp_way), 32'(n_way));
        chk("R6", "predict_hit", 32'(predict_hit), 32'(n_ph));
        chk("R6", "full_probe", 32'(full_probe), 32'(n_fp));
        chk("R8", "hit_count", 32'(hit_count), 32'(m_hc));
        chk("R8", "miss_count", 32'(miss_count), 32'(m_mc));
    endtask

    task automatic req(logic [7:0] vt, logic [5:0] vi, logic [19:0] pt, logic [5:0] ps);
        rq = 1; va = {12'h0, vt, vi, 6'h0}; pa = {pt, ps, 6'h0};
        tick();
        rq = 0;
        while (m_retry) tick();
    endtask

    task automatic fill(logic [5:0] s, logic [1:0] w, logic [19:0] t);
        fv = 1; fset = s; fway = w; ftag = t;
        tick();
        fv = 0;
    endtask

    task automatic inval(logic [5:0] s, logic [1:0] w);
        iv = 1; iset = s; iway = w;
        tick();
        iv = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_pv[i] = 0;
            for (int w = 0; w < 4; w++) m_cv[i][w] = 0;
        end
        m_retry = 0; m_hc = 0; m_mc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        scen = "R1";
        chk("R1", "reset resp_valid", 32'(resp_valid), 0);
        chk("R1", "reset hit_count", 32'(hit_count), 0);
        chk("R1", "reset miss_count", 32'(miss_count), 0);
        chk("R1", "reset req_ready", 32'(req_ready), 1);
        chk("R1", "reset way_en", 32'(way_en), 0);
        @(negedge clk);

        scen = "R3";
        fill(6'd5, 2'd2, 20'hABC);
        req(8'h11, 6'd5, 20'hABC, 6'd5);   // table miss, full probe hit way 2
        req(8'h11, 6'd5, 20'hABC, 6'd5);   // now predicted, way_en 0100
        tick();

        scen = "R9";
        req(8'h31, 6'd9, 20'h123, 6'd9);   // cache miss
        req(8'h31, 6'd9, 20'h123, 6'd9);   // still a table miss

        scen = "R5";
        req(8'h11, 6'd5, 20'hDEF, 6'd5);   // alias: mispredict, re-probe miss, entry dropped
        req(8'h11, 6'd5, 20'hABC, 6'd5);   // table miss, rewritten
        fill(6'd5, 2'd0, 20'hDEF);
        req(8'h11, 6'd5, 20'hDEF, 6'd5);   // mispredict, re-probe hit way 0
        req(8'h11, 6'd5, 20'hDEF, 6'd5);   // predicted way 0

        scen = "R7";
        inval(6'd5, 2'd0);
        req(8'h11, 6'd5, 20'hDEF, 6'd5);   // table miss, cache miss
        req(8'h11, 6'd5, 20'hABC, 6'd5);
        req(8'h11, 6'd5, 20'hABC, 6'd5);
        fill(6'd5, 2'd2, 20'h777);         // replaces line, drops pointer
        req(8'h11, 6'd5, 20'h777, 6'd5);

        scen = "R10";
        req(8'h22, 6'd5, 20'h777, 6'd5);   // other partial tag replaces occupant
        req(8'h11, 6'd5, 20'h777, 6'd5);   // old occupant misses table
        req(8'h11, 6'd5, 20'h777, 6'd5);

        scen = "R4";
        for (int s = 16; s < 24; s++)
            for (int w = 0; w < 4; w++)
                fill(6'(s), 2'(w), 20'h100 + 20'(s * 4 + w));
        for (int r = 0; r < 3; r++) begin
            for (int j = 0; j < 32; j++) begin
                int s = 16 + (j % 8);
                int w = (j * 3) % 4;
                logic [7:0] vt = (r < 2) ? 8'(8'h40 + w) : 8'h40;
                rq = 1; va = {12'h0, vt, 6'(s), 6'h0}; pa = {20'h100 + 20'(s * 4 + w), 6'(s), 6'h0};
                tick();
            end
            rq = 0;
            while (m_retry) tick();
        end
        scen = "R6";
        repeat (3) tick();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule